// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node side of a directory-based coherence scheme for a small multiprocessor that has no broadcast medium. For each memory block it owns, it keeps a directory entry (a coherence state plus a presence vector with one bit per processor) and the backing data word. Caches send it misses and write-backs. It answers with data replies, and when the coherence rules require it, it first sends invalidations to the processors that share the block or recalls the block from its current owner.

The controller serves one request at a time. A write miss to a shared block produces a burst of invalidations, one per cycle. The burst walks the presence vector from the lowest processor index upward, skips the requester, and ends with the data reply. A miss to a block that some processor holds exclusively sends a recall to that owner. The controller then stalls, with its request input not ready, until the owner's data arrives on a dedicated response input. That data is written to memory and forwarded to the requester.

Top module: `home_dir`

## Requirements
- R1: After reset, every block is Uncached with an empty presence vector, and block b holds the data word 0xA000 + b. No message is valid and `req_ready` is high. A reset in the middle of an operation abandons the operation.
- R2: A read miss (`req_kind` 0) to an Uncached block sends, one cycle after acceptance, a data reply (`msg_kind` 0) to the requester carrying the memory word. The block becomes Shared with the requester as its only sharer.
- R3: A read miss to a Shared block sends a data reply carrying the memory word and adds the requester to the presence vector, keeping all earlier sharers.
- R4: A write miss (`req_kind` 1) to an Uncached block sends a data reply carrying the memory word and makes the requester the exclusive owner.
- R5: A write miss to a Shared block sends an invalidate (`msg_kind` 1) to every sharer except the requester. The invalidates go out in ascending processor index, one per cycle on consecutive cycles, and are followed by the data reply. The block becomes Exclusive with the requester as owner. If the requester is the only sharer, the reply follows acceptance directly.
- R6: A read miss to an Exclusive block sends a recall (`msg_kind` 2) to the owner. The response data is written to memory and sent to the requester in a data reply. The block becomes Shared, with both the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a recall-and-invalidate (`msg_kind` 3) to the owner. The response data is written to memory and forwarded to the requester, which becomes the sole owner. The block stays Exclusive.
- R8: A write-back (`req_kind` 2) from the owner of an Exclusive block writes its data to memory, empties the presence vector and makes the block Uncached. It sends no message.
- R9: A write-back from a processor that is not the owner, or to a block that is not Exclusive, is ignored. It sends no message and changes neither the directory entry nor memory.
- R10: While invalidates are being sent or an owner response is awaited, `req_ready` is low and no request is accepted. While the response is awaited, no message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a valid request is taken on this edge |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Write-back data |
| rsp_valid | input | 1 | Owner response data present |
| rsp_data | input | DW | Block data returned by the owner |
| msg_valid | output | 1 | Outgoing message valid for one cycle |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 recall, 3 recall-and-invalidate |
| msg_dst | output | $clog2(NPROC) | Destination processor |
| msg_blk | output | $clog2(NBLK) | Block the message concerns |
| msg_data | output | DW | Reply data (zero for other kinds) |

## Verification
The hardest state to reach from the ports is a stalled owner recall with a competing request held on the input. It needs a block made Exclusive, a miss from a second processor, and then a response that the bench withholds for several cycles while it drives another valid request. The bench builds this sequence directly, then checks that the controller stays silent and not ready, that the competing request never produces a message, and that the late data reaches the requester. Directory contents cannot be read out, so they are exposed through later traffic: a following write miss reveals the presence vector through its invalidate targets, and a following read reveals the memory word or a recall.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2,
        RQ_NONE  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MG_DATA      = 2'd0,
        MG_INV       = 2'd1,
        MG_FETCH     = 2'd2,
        MG_FETCH_INV = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INVAL = 2'd1,
        ST_REPLY = 2'd2,
        ST_WAIT  = 2'd3
    } fsm_e;

    localparam int unsigned SEED_BASE = 32'h0000_A000;

    function automatic int unsigned seed_word(int unsigned b);
        return SEED_BASE + b;
    endfunction

endpackage

// File: rtl/sharer_pick.sv
module sharer_pick #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    // lowest set bit wins: the descending scan lets smaller indices override
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
        oh  = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/dir_store.sv
module dir_store
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int BW = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BW-1:0]    blk,
    output dstate_e          rd_state,
    output logic [NPROC-1:0] rd_shr,
    output logic [DW-1:0]    rd_data,
    input  logic             dir_we,
    input  dstate_e          dir_wstate,
    input  logic [NPROC-1:0] dir_wshr,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_wdata
);
    dstate_e          st_q  [NBLK];
    logic [NPROC-1:0] shr_q [NBLK];
    logic [DW-1:0]    mem_q [NBLK];

    assign rd_state = st_q[blk];
    assign rd_shr   = shr_q[blk];
    assign rd_data  = mem_q[blk];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBLK; b++) begin
                st_q[b]  <= DS_UNC;
                shr_q[b] <= '0;
                mem_q[b] <= DW'(seed_word(b));
            end
        end else begin
            if (dir_we) begin
                st_q[blk]  <= dir_wstate;
                shr_q[blk] <= dir_wshr;
            end
            if (mem_we) mem_q[blk] <= mem_wdata;
        end
    end

    // every entry keeps a presence vector consistent with its state (R1, R2, R4, R6, R8)
    for (genvar g = 0; g < NBLK; g++) begin : g_chk
        a_r1_entry_legal: assert property (@(posedge clk) disable iff (rst)
            ((st_q[g] == DS_UNC) -> (shr_q[g] == '0)) &&
            ((st_q[g] == DS_SHR) -> (shr_q[g] != '0)) &&
            ((st_q[g] == DS_EXC) -> $onehot(shr_q[g])) &&
            (st_q[g] != dstate_e'(2'd3)));
    end
endmodule

// File: rtl/home_dir.sv
module home_dir
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int IW = $clog2(NPROC),
    localparam int BW = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [IW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [IW-1:0] msg_dst,
    output logic [BW-1:0] msg_blk,
    output logic [DW-1:0] msg_data
);
    typedef struct packed {
        req_kind_e     kind;
        logic [IW-1:0] src;
        logic [BW-1:0] blk;
    } cur_t;

    typedef struct packed {
        logic          valid;
        msg_kind_e     kind;
        logic [IW-1:0] dst;
        logic [BW-1:0] blk;
        logic [DW-1:0] data;
    } msg_t;

    fsm_e             st_q, st_n;
    cur_t             cur_q, cur_n;
    msg_t             msg_q, msg_n;
    logic [NPROC-1:0] pend_q, pend_n;

    logic [BW-1:0]    acc_blk;
    dstate_e          ent_state;
    logic [NPROC-1:0] ent_shr;
    logic [DW-1:0]    ent_data;
    logic             dir_we, mem_we;
    dstate_e          dir_wstate;
    logic [NPROC-1:0] dir_wshr;
    logic [DW-1:0]    mem_wdata;

    logic [NPROC-1:0] pick_vec, pick_oh;
    logic             pick_any;
    logic [IW-1:0]    pick_idx;

    logic [NPROC-1:0] new_bit, cur_bit, others;
    logic             idle;

    assign idle      = (st_q == ST_IDLE);
    assign req_ready = idle;
    assign acc_blk   = idle ? req_blk : cur_q.blk;
    assign new_bit   = NPROC'(1) << req_src;
    assign cur_bit   = NPROC'(1) << cur_q.src;
    assign others    = ent_shr & ~new_bit;
    assign pick_vec  = (st_q == ST_INVAL) ? pend_q : ent_shr;

    dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .blk        (acc_blk),
        .rd_state   (ent_state),
        .rd_shr     (ent_shr),
        .rd_data    (ent_data),
        .dir_we     (dir_we),
        .dir_wstate (dir_wstate),
        .dir_wshr   (dir_wshr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata)
    );

    // one picker serves both the owner lookup and the invalidate scan
    sharer_pick #(.N(NPROC)) u_pick (
        .vec (pick_vec),
        .any (pick_any),
        .idx (pick_idx),
        .oh  (pick_oh)
    );

    always_comb begin
        st_n       = st_q;
        cur_n      = cur_q;
        pend_n     = pend_q;
        msg_n      = '0;
        msg_n.blk  = acc_blk;
        dir_we     = 1'b0;
        dir_wstate = DS_UNC;
        dir_wshr   = '0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cur_n = '{kind: req_kind_e'(req_kind), src: req_src, blk: req_blk};
                    unique case (req_kind_e'(req_kind))
                        RQ_READ: begin
                            if (ent_state == DS_EXC) begin
                                msg_n = '{1'b1, MG_FETCH, pick_idx, req_blk, '0};
                                st_n  = ST_WAIT;
                            end else begin
                                msg_n      = '{1'b1, MG_DATA, req_src, req_blk, ent_data};
                                dir_we     = 1'b1;
                                dir_wstate = DS_SHR;
                                dir_wshr   = (ent_state == DS_SHR) ? (ent_shr | new_bit) : new_bit;
                            end
                        end
                        RQ_WRITE: begin
                            if (ent_state == DS_EXC) begin
                                msg_n = '{1'b1, MG_FETCH_INV, pick_idx, req_blk, '0};
                                st_n  = ST_WAIT;
                            end else if (ent_state == DS_SHR && others != '0) begin
                                pend_n = others;
                                st_n   = ST_INVAL;
                            end else begin
                                msg_n      = '{1'b1, MG_DATA, req_src, req_blk, ent_data};
                                dir_we     = 1'b1;
                                dir_wstate = DS_EXC;
                                dir_wshr   = new_bit;
                            end
                        end
                        RQ_WBACK: begin
                            if (ent_state == DS_EXC && ent_shr == new_bit) begin
                                mem_we     = 1'b1;
                                mem_wdata  = req_data;
                                dir_we     = 1'b1;
                                dir_wstate = DS_UNC;
                                dir_wshr   = '0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_INVAL: begin
                if (pick_any) begin
                    msg_n = '{1'b1, MG_INV, pick_idx, cur_q.blk, '0};
                end
                pend_n = pend_q & ~pick_oh;
                if ((pend_q & ~pick_oh) == '0) st_n = ST_REPLY;
            end
            ST_REPLY: begin
                msg_n      = '{1'b1, MG_DATA, cur_q.src, cur_q.blk, ent_data};
                dir_we     = 1'b1;
                dir_wstate = DS_EXC;
                dir_wshr   = cur_bit;
                st_n       = ST_IDLE;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    msg_n      = '{1'b1, MG_DATA, cur_q.src, cur_q.blk, rsp_data};
                    mem_we     = 1'b1;
                    mem_wdata  = rsp_data;
                    dir_we     = 1'b1;
                    if (cur_q.kind == RQ_READ) begin
                        dir_wstate = DS_SHR;
                        dir_wshr   = ent_shr | cur_bit;
                    end else begin
                        dir_wstate = DS_EXC;
                        dir_wshr   = cur_bit;
                    end
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            pend_q <= '0;
            msg_q  <= '0;
        end else begin
            st_q   <= st_n;
            cur_q  <= cur_n;
            pend_q <= pend_n;
            msg_q  <= msg_n;
        end
    end

    assign msg_valid = msg_q.valid;
    assign msg_kind  = msg_q.kind;
    assign msg_dst   = msg_q.dst;
    assign msg_blk   = msg_q.blk;
    assign msg_data  = msg_q.data;

    // R5: an invalidate never targets the processor whose write caused it
    a_r5_inv_skips_req: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MG_INV) |-> (msg_dst != cur_q.src));

    // R5: the end of an invalidate burst is followed by the data reply
    a_r5_burst_then_reply: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REPLY) |=> (msg_valid && msg_kind == MG_DATA));

    // R6, R7: a recall is always followed by waiting for the owner
    a_r6_recall_waits: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && (msg_kind == MG_FETCH || msg_kind == MG_FETCH_INV)) |-> (st_q == ST_WAIT));

    // R10: nothing is sent while the owner response is outstanding
    a_r10_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && !rsp_valid) |=> !msg_valid);

    // R8, R9: a write-back never produces a message
    a_r8_wback_silent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == 2'd2) |=> !msg_valid);
endmodule

// File: tb/sim_home_dir.sv
`timescale 1ns/1ps
module sim_home_dir;
    localparam int NP = 4;
    localparam int NB = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_src = '0;
    logic [2:0]    req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          msg_valid;
    logic [1:0]    msg_kind;
    logic [1:0]    msg_dst;
    logic [2:0]    msg_blk;
    logic [DW-1:0] msg_data;

    home_dir #(.NPROC(NP), .NBLK(NB), .DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
        .msg_blk(msg_blk), .msg_data(msg_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // message log of the last request
    int          lg_n;
    logic [1:0]  lg_kind [16];
    logic [1:0]  lg_dst  [16];
    logic [2:0]  lg_blk  [16];
    logic [15:0] lg_data [16];
    int          lg_cyc  [16];
    int          busy_bad;

    task automatic run_req(input logic [1:0] k, input logic [1:0] s, input logic [2:0] b,
                           input logic [15:0] d, input logic [15:0] r, input int hold);
        bit fetched = 0;
        bit served  = 0;
        int cnt = hold;
        lg_n = 0;
        busy_bad = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = s; req_blk = b; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 60; i++) begin
            bit fetch_now = 0;
            if (msg_valid && lg_n < 16) begin
                lg_kind[lg_n] = msg_kind; lg_dst[lg_n] = msg_dst;
                lg_blk[lg_n]  = msg_blk;  lg_data[lg_n] = msg_data;
                lg_cyc[lg_n]  = cyc;
                lg_n = lg_n + 1;
            end
            if (msg_valid && msg_kind[1]) begin fetched = 1; fetch_now = 1; end
            rsp_valid = 1'b0;
            if (fetched && !served) begin
                if (!fetch_now && (req_ready || msg_valid)) busy_bad = busy_bad + 1;
                if (cnt == 0) begin
                    rsp_valid = 1'b1; rsp_data = r; served = 1;
                end else cnt = cnt - 1;
            end
            if (req_ready && !msg_valid && !rsp_valid) break;
            @(negedge clk);
        end
        rsp_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  kind;
        logic [1:0]  src;
        logic [2:0]  blk;
        logic [15:0] data;
        logic [15:0] rsp;
        logic [3:0]  n;
        logic [1:0]  fk;
        logic [1:0]  fd;
        logic [1:0]  ld;
        logic [15:0] ldat;
    } vec_t;

    // kind: 0 read, 1 write, 2 write-back. fk: first message kind. last message is always a data reply.
    localparam vec_t TBL [18] = '{
        '{2'd0, 2'd1, 3'd0, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd1, 2'd1, 16'hA000}, // R2 R1 seed word
        '{2'd0, 2'd3, 3'd0, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd3, 2'd3, 16'hA000}, // R3
        '{2'd0, 2'd0, 3'd0, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd0, 2'd0, 16'hA000}, // R3
        '{2'd1, 2'd1, 3'd0, 16'h0000, 16'h0000, 4'd3, 2'd1, 2'd0, 2'd1, 16'hA000}, // R5 invs 0,3
        '{2'd0, 2'd2, 3'd0, 16'h0000, 16'h1111, 4'd2, 2'd2, 2'd1, 2'd2, 16'h1111}, // R6
        '{2'd1, 2'd3, 3'd0, 16'h0000, 16'h0000, 4'd3, 2'd1, 2'd1, 2'd3, 16'h1111}, // R6 sharers 1,2
        '{2'd1, 2'd0, 3'd0, 16'h0000, 16'h2222, 4'd2, 2'd3, 2'd3, 2'd0, 16'h2222}, // R7
        '{2'd2, 2'd2, 3'd0, 16'h9999, 16'h0000, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0000}, // R9 non-owner
        '{2'd0, 2'd1, 3'd0, 16'h0000, 16'h2A2A, 4'd2, 2'd2, 2'd0, 2'd1, 16'h2A2A}, // R9 owner kept, R7 owner 0
        '{2'd2, 2'd0, 3'd0, 16'h7777, 16'h0000, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0000}, // R9 block shared
        '{2'd1, 2'd2, 3'd0, 16'h0000, 16'h0000, 4'd3, 2'd1, 2'd0, 2'd2, 16'h2A2A}, // R9 memory kept
        '{2'd2, 2'd2, 3'd0, 16'h3333, 16'h0000, 4'd0, 2'd0, 2'd0, 2'd0, 16'h0000}, // R8
        '{2'd0, 2'd3, 3'd0, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd3, 2'd3, 16'h3333}, // R8 uncached, data
        '{2'd1, 2'd1, 3'd5, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd1, 2'd1, 16'hA005}, // R4
        '{2'd0, 2'd0, 3'd5, 16'h0000, 16'h5555, 4'd2, 2'd2, 2'd1, 2'd0, 16'h5555}, // R4 owner 1
        '{2'd1, 2'd0, 3'd5, 16'h0000, 16'h0000, 4'd2, 2'd1, 2'd1, 2'd0, 16'h5555}, // R5 skip requester
        '{2'd0, 2'd2, 3'd7, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd2, 2'd2, 16'hA007}, // R2
        '{2'd1, 2'd2, 3'd7, 16'h0000, 16'h0000, 4'd1, 2'd0, 2'd2, 2'd2, 16'hA007}  // R5 sole sharer upgrade
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(msg_valid == 1'b0, "R1", "msg_valid in reset", msg_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(msg_valid == 1'b0, "R1", "msg_valid after reset", msg_valid, 0);

        for (int v = 0; v < 18; v++) begin
            vec_t e = TBL[v];
            run_req(e.kind, e.src, e.blk, e.data, e.rsp, 0);
            chk(lg_n == int'(e.n), $sformatf("vec%0d", v), "message count", lg_n, e.n);
            if (e.n != 0 && lg_n == int'(e.n)) begin
                chk(lg_kind[0] == e.fk && lg_dst[0] == e.fd, $sformatf("vec%0d", v),
                    "first kind/dst", {lg_kind[0], 2'b0, lg_dst[0]}, {e.fk, 2'b0, e.fd});
                chk(lg_kind[lg_n-1] == 2'd0 && lg_dst[lg_n-1] == e.ld && lg_blk[lg_n-1] == e.blk,
                    $sformatf("vec%0d", v), "reply kind/dst/blk",
                    {lg_kind[lg_n-1], lg_dst[lg_n-1], lg_blk[lg_n-1]}, {2'd0, e.ld, e.blk});
                chk(lg_data[lg_n-1] == e.ldat, $sformatf("vec%0d", v), "reply data",
                    lg_data[lg_n-1], e.ldat);
            end
        end

        // R5: four sharers, write by P2 -> invalidates 0,1,3 on consecutive cycles, then reply
        for (int p = 0; p < 4; p++) run_req(2'd0, 2'(p), 3'd6, 16'h0, 16'h0, 0);
        run_req(2'd1, 2'd2, 3'd6, 16'h0, 16'h0, 0);
        chk(lg_n == 4, "R5", "fan-out count", lg_n, 4);
        if (lg_n == 4) begin
            chk(lg_kind[0] == 2'd1 && lg_dst[0] == 2'd0, "R5", "inv#0 dst", lg_dst[0], 0);
            chk(lg_kind[1] == 2'd1 && lg_dst[1] == 2'd1, "R5", "inv#1 dst", lg_dst[1], 1);
            chk(lg_kind[2] == 2'd1 && lg_dst[2] == 2'd3, "R5", "inv#2 dst", lg_dst[2], 3);
            chk(lg_cyc[1] == lg_cyc[0] + 1 && lg_cyc[2] == lg_cyc[1] + 1, "R5",
                "invalidate spacing", lg_cyc[2] - lg_cyc[0], 2);
            chk(lg_kind[3] == 2'd0 && lg_dst[3] == 2'd2 && lg_data[3] == 16'hA006, "R5",
                "final reply data", lg_data[3], 16'hA006);
        end

        // R10: delayed owner response, busy window checked inside run_req
        run_req(2'd1, 2'd0, 3'd4, 16'h0, 16'h0, 0);
        run_req(2'd0, 2'd1, 3'd4, 16'h0, 16'hBEEF, 5);
        chk(busy_bad == 0, "R10", "ready/msg during wait", busy_bad, 0);
        chk(lg_n == 2 && lg_data[1] == 16'hBEEF, "R10", "late data forwarded", lg_data[1], 16'hBEEF);

        // R10: competing request held during the wait is not accepted
        run_req(2'd1, 2'd0, 3'd3, 16'h0, 16'h0, 0);
        req_valid = 1'b1; req_kind = 2'd0; req_src = 2'd1; req_blk = 3'd3;
        @(negedge clk);
        chk(msg_valid && msg_kind == 2'd2 && msg_dst == 2'd0, "R6", "recall to owner 0",
            {msg_kind, msg_dst}, {2'd2, 2'd0});
        req_src = 2'd2; req_blk = 3'd1;   // competitor: read by P2 of block 1
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!req_ready && !msg_valid, "R10", "quiet while waiting", {req_ready, msg_valid}, 0);
        end
        req_valid = 1'b0;
        rsp_valid = 1'b1; rsp_data = 16'hC0DE;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(msg_valid && msg_dst == 2'd1 && msg_data == 16'hC0DE, "R10", "reply after hold",
            msg_data, 16'hC0DE);
        @(negedge clk);
        chk(!msg_valid && req_ready, "R10", "competitor dropped", {msg_valid, req_ready}, 2'b01);

        // R1: reset during a wait abandons it and restores the seed contents
        run_req(2'd1, 2'd2, 3'd2, 16'h0, 16'h0, 0);
        req_valid = 1'b1; req_kind = 2'd0; req_src = 2'd0; req_blk = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk(msg_valid && msg_kind == 2'd2, "R6", "recall before reset", msg_kind, 2);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !msg_valid, "R1", "idle after mid-op reset", {req_ready, msg_valid}, 2'b10);
        run_req(2'd0, 2'd1, 3'd2, 16'h0, 16'h0, 0);
        chk(lg_n == 1 && lg_kind[0] == 2'd0 && lg_data[0] == 16'hA002, "R1",
            "uncached seed after reset", lg_data[0], 16'hA002);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule